// File: doc/BRIEF.md
# Per-Warp Register Busy Tracker

This block tells an in-order issue stage whether an instruction can leave issue. It remembers which destination registers belong to instructions that have issued but not yet written back. Integer and float registers have a separate busy set for every warp. Vector registers have one busy set that all warps share.

Each cycle the issue stage presents a warp number, three source/destination usage masks (integer, float and vector) and a destination index with its class. The block answers with a stall or a go. On a go it marks the destination register busy. A separate writeback port names a warp, a destination index and a class, and frees that register.

The block does not forward results, hold register values or decode instructions.

Top module: `warp_reg_scoreboard`

## Requirements
- R1: After reset, or in the cycle after `clear` is high, every busy set of every warp is empty. A clear also overrides any issue mark or writeback in the same cycle.
- R2: `iss_stall` is high only when `iss_valid` is high and some usage mask overlaps the busy set that applies. `iss_go` equals `iss_valid` and not `iss_stall`. Both are low while `iss_valid` is low.
- R3: Integer and float busy sets are kept per warp and per class. A mark or a free for one warp or class has no effect on any other warp or class.
- R4: Vector busy bits are shared by all warps. A vector destination marked or freed by any warp affects the stall of every warp.
- R5: The destination class is encoded as 1 = integer, 2 = float, 3 = vector. Value 0 means there is no tracked destination. On a go, the destination register of the given class becomes busy from the next cycle on.
- R6: Integer register 0 is never marked busy.
- R7: A stalled issue marks nothing busy.
- R8: When `wb_valid` is high, the named register of the named class is freed from the next cycle on. A writeback with class 0 changes nothing.
- R9: A writeback does not affect the stall decision in its own cycle. When an issue and a writeback hit the same bit in one cycle, the free is applied first and the mark second, so the bit stays busy.
- R10: Bit i of each usage mask refers to register i of that class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous flush of all busy sets |
| iss_valid | input | 1 | An instruction is waiting in issue |
| iss_warp | input | WID_W | Warp of the waiting instruction |
| iss_int_mask | input | NUM_REGS | Integer registers the instruction uses |
| iss_flt_mask | input | NUM_REGS | Float registers the instruction uses |
| iss_vec_mask | input | NUM_REGS | Vector registers the instruction uses |
| iss_dst | input | RIX_W | Destination register index |
| iss_dtype | input | 2 | Destination class (0 none, 1 int, 2 float, 3 vector) |
| iss_stall | output | 1 | Hazard found; hold the instruction |
| iss_go | output | 1 | Instruction leaves issue this cycle |
| wb_valid | input | 1 | A result is written back |
| wb_warp | input | WID_W | Warp of the written-back result |
| wb_dst | input | RIX_W | Register index being freed |
| wb_dtype | input | 2 | Class of the freed register |

## Verification
A busy bit that is wrongly set shows up as a stall on the next probe of that warp, class and index. A bit that is wrongly cleared, or written to the wrong warp or class, shows up as a missing stall one cycle after the mark or free. The bench therefore follows every mark or free with single-bit probes on the intended set and on its neighbours: other warps, other classes and other indices. Each probe is checked in the cycle it is presented.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
   typedef enum logic [1:0] {
      DK_NONE = 2'd0,
      DK_INT  = 2'd1,
      DK_FLT  = 2'd2,
      DK_VEC  = 2'd3
   } dst_kind_e;

   localparam int NUM_CLASSES = 3;
   localparam int CLS_INT     = 0;
   localparam int CLS_FLT     = 1;
   localparam int CLS_VEC     = 2;
endpackage

// File: rtl/wsb_dest_dec.sv
module wsb_dest_dec
   import wsb_pkg::*;
(
   input  logic                   en,
   input  logic [1:0]             kind,
   output logic [NUM_CLASSES-1:0] cls_en
);
   always_comb begin
      cls_en = '0;
      if (en) begin
         unique case (dst_kind_e'(kind))
            DK_INT:  cls_en[CLS_INT] = 1'b1;
            DK_FLT:  cls_en[CLS_FLT] = 1'b1;
            DK_VEC:  cls_en[CLS_VEC] = 1'b1;
            default: cls_en = '0;
         endcase
      end
   end
endmodule

// File: rtl/wsb_bank.sv
module wsb_bank #(
   parameter int NSETS     = 4,
   parameter int NUM_REGS  = 32,
   parameter int SEL_W     = 2,
   parameter bit SKIP_ZERO = 1'b0,
   localparam int RIX_W    = $clog2(NUM_REGS),
   localparam bit SHARED   = (NSETS == 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                set_en,
   input  logic [SEL_W-1:0]    set_sel,
   input  logic [RIX_W-1:0]    set_idx,
   input  logic                clr_en,
   input  logic [SEL_W-1:0]    clr_sel,
   input  logic [RIX_W-1:0]    clr_idx,
   input  logic [SEL_W-1:0]    rd_sel,
   output logic [NUM_REGS-1:0] rd_vec
);
   logic [NSETS-1:0][NUM_REGS-1:0] busy;

   function automatic logic hit(input logic [SEL_W-1:0] sel, input int s);
      return SHARED || (sel == SEL_W'(s));
   endfunction

   logic set_ok;
   assign set_ok = set_en && !(SKIP_ZERO && (set_idx == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= '0;
      end else if (clear) begin
         busy <= '0;
      end else begin
         for (int s = 0; s < NSETS; s++) begin
            // free first, then mark: a later NBA to the same bit wins
            if (clr_en && hit(clr_sel, s)) busy[s][clr_idx] <= 1'b0;
            if (set_ok && hit(set_sel, s)) busy[s][set_idx] <= 1'b1;
         end
      end
   end

   always_comb begin
      rd_vec = '0;
      for (int s = 0; s < NSETS; s++) begin
         if (hit(rd_sel, s)) rd_vec = rd_vec | busy[s];
      end
   end
endmodule

// File: rtl/wsb_hazard.sv
module wsb_hazard
   import wsb_pkg::*;
#(
   parameter int NUM_REGS = 32
) (
   input  logic                                  valid,
   input  logic [NUM_CLASSES-1:0][NUM_REGS-1:0]  use_mask,
   input  logic [NUM_CLASSES-1:0][NUM_REGS-1:0]  busy,
   output logic                                  stall
);
   logic [NUM_CLASSES-1:0] cls_hit;

   for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
      assign cls_hit[c] = |(use_mask[c] & busy[c]);
   end

   assign stall = valid && (|cls_hit);
endmodule

// File: rtl/warp_reg_scoreboard.sv
module warp_reg_scoreboard
   import wsb_pkg::*;
#(
   parameter int NUM_WARPS = 4,
   parameter int NUM_REGS  = 32,
   localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
   localparam int RIX_W    = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                iss_valid,
   input  logic [WID_W-1:0]    iss_warp,
   input  logic [NUM_REGS-1:0] iss_int_mask,
   input  logic [NUM_REGS-1:0] iss_flt_mask,
   input  logic [NUM_REGS-1:0] iss_vec_mask,
   input  logic [RIX_W-1:0]    iss_dst,
   input  logic [1:0]          iss_dtype,
   output logic                iss_stall,
   output logic                iss_go,
   input  logic                wb_valid,
   input  logic [WID_W-1:0]    wb_warp,
   input  logic [RIX_W-1:0]    wb_dst,
   input  logic [1:0]          wb_dtype
);
   if (NUM_WARPS < 1) begin : g_bad_warps
      $error("warp_reg_scoreboard: NUM_WARPS must be at least 1");
   end
   if (NUM_REGS < 2 || (1 << RIX_W) != NUM_REGS) begin : g_bad_regs
      $error("warp_reg_scoreboard: NUM_REGS must be a power of two >= 2");
   end

   logic [NUM_CLASSES-1:0]                set_cls;
   logic [NUM_CLASSES-1:0]                clr_cls;
   logic [NUM_CLASSES-1:0][NUM_REGS-1:0]  busy_rd;
   logic [NUM_CLASSES-1:0][NUM_REGS-1:0]  use_mask;

   assign use_mask[CLS_INT] = iss_int_mask;
   assign use_mask[CLS_FLT] = iss_flt_mask;
   assign use_mask[CLS_VEC] = iss_vec_mask;

   wsb_hazard #(.NUM_REGS(NUM_REGS)) u_haz (
      .valid    (iss_valid),
      .use_mask (use_mask),
      .busy     (busy_rd),
      .stall    (iss_stall)
   );

   assign iss_go = iss_valid && !iss_stall;

   wsb_dest_dec u_set_dec (.en(iss_go),   .kind(iss_dtype), .cls_en(set_cls));
   wsb_dest_dec u_clr_dec (.en(wb_valid), .kind(wb_dtype),  .cls_en(clr_cls));

   for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_bank
      localparam int  NSETS = (c == CLS_VEC) ? 1 : NUM_WARPS;
      localparam bit  SKIPZ = (c == CLS_INT);
      wsb_bank #(
         .NSETS     (NSETS),
         .NUM_REGS  (NUM_REGS),
         .SEL_W     (WID_W),
         .SKIP_ZERO (SKIPZ)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear   (clear),
         .set_en  (set_cls[c]),
         .set_sel (iss_warp),
         .set_idx (iss_dst),
         .clr_en  (clr_cls[c]),
         .clr_sel (wb_warp),
         .clr_idx (wb_dst),
         .rd_sel  (iss_warp),
         .rd_vec  (busy_rd[c])
      );
   end
endmodule

// File: rtl/wsb_checker.sv
module wsb_checker #(
   parameter int NUM_WARPS = 4,
   parameter int NUM_REGS  = 32,
   localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
   localparam int RIX_W    = $clog2(NUM_REGS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                clear,
   input logic                iss_valid,
   input logic [WID_W-1:0]    iss_warp,
   input logic [NUM_REGS-1:0] iss_int_mask,
   input logic [NUM_REGS-1:0] iss_flt_mask,
   input logic [NUM_REGS-1:0] iss_vec_mask,
   input logic [RIX_W-1:0]    iss_dst,
   input logic [1:0]          iss_dtype,
   input logic                iss_stall,
   input logic                iss_go,
   input logic                wb_valid,
   input logic [WID_W-1:0]    wb_warp,
   input logic [RIX_W-1:0]    wb_dst,
   input logic [1:0]          wb_dtype
);
   localparam logic [NUM_REGS-1:0] ONE = NUM_REGS'(1);

   logic only_int;
   assign only_int = (iss_flt_mask == '0) && (iss_vec_mask == '0);

   p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(iss_stall && iss_go));

   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_valid |-> (!iss_stall && !iss_go));

   p_clear_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> !iss_stall);

   p_zero_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && only_int && iss_int_mask == ONE) |-> !iss_stall);

   p_int_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_go && iss_dtype == 2'd1 && iss_dst != '0 && !clear) |=>
      (!(iss_valid && iss_warp == $past(iss_warp) &&
         iss_int_mask[$past(iss_dst)]) || iss_stall));

   p_wb_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_dtype == 2'd1 &&
       !(iss_go && iss_dtype == 2'd1 && iss_warp == wb_warp && iss_dst == wb_dst)) |=>
      (!(iss_valid && iss_warp == $past(wb_warp) && only_int &&
         iss_int_mask == (ONE << $past(wb_dst))) || !iss_stall));
endmodule

bind warp_reg_scoreboard wsb_checker #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .clear        (clear),
   .iss_valid    (iss_valid),
   .iss_warp     (iss_warp),
   .iss_int_mask (iss_int_mask),
   .iss_flt_mask (iss_flt_mask),
   .iss_vec_mask (iss_vec_mask),
   .iss_dst      (iss_dst),
   .iss_dtype    (iss_dtype),
   .iss_stall    (iss_stall),
   .iss_go       (iss_go),
   .wb_valid     (wb_valid),
   .wb_warp      (wb_warp),
   .wb_dst       (wb_dst),
   .wb_dtype     (wb_dtype)
);

// File: tb/warp_reg_scoreboard_test.sv
`timescale 1ns/1ps
module warp_reg_scoreboard_test;
   localparam int NW = 4;
   localparam int NR = 32;
   localparam logic [1:0] K0 = 2'd0, KI = 2'd1, KF = 2'd2, KV = 2'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clear = 1'b0;
   logic iss_valid = 1'b0;
   logic [1:0] iss_warp = '0;
   logic [NR-1:0] iss_int_mask = '0, iss_flt_mask = '0, iss_vec_mask = '0;
   logic [4:0] iss_dst = '0;
   logic [1:0] iss_dtype = '0;
   logic iss_stall, iss_go;
   logic wb_valid = 1'b0;
   logic [1:0] wb_warp = '0;
   logic [4:0] wb_dst = '0;
   logic [1:0] wb_dtype = '0;

   always #2.5 clk = ~clk;

   warp_reg_scoreboard #(.NUM_WARPS(NW), .NUM_REGS(NR)) uut (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .iss_valid(iss_valid), .iss_warp(iss_warp),
      .iss_int_mask(iss_int_mask), .iss_flt_mask(iss_flt_mask), .iss_vec_mask(iss_vec_mask),
      .iss_dst(iss_dst), .iss_dtype(iss_dtype),
      .iss_stall(iss_stall), .iss_go(iss_go),
      .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_dst(wb_dst), .wb_dtype(wb_dtype)
   );

   typedef struct {
      bit    v;
      bit    es;
      string tag;
   } exp_t;

   exp_t expq[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   function automatic logic [NR-1:0] b(input int k);
      return NR'(1) << k;
   endfunction

   // driver: one item pushed per driven cycle
   task automatic step(input bit v, input int w, input logic [NR-1:0] im, fm, vm,
                       input int dst, input logic [1:0] dt,
                       input bit wv, input int ww, input int wd, input logic [1:0] wt,
                       input bit clr, input bit es, input string tag);
      exp_t e;
      @(negedge clk);
      iss_valid = v; iss_warp = 2'(w);
      iss_int_mask = im; iss_flt_mask = fm; iss_vec_mask = vm;
      iss_dst = 5'(dst); iss_dtype = dt;
      wb_valid = wv; wb_warp = 2'(ww); wb_dst = 5'(wd); wb_dtype = wt;
      clear = clr;
      e.v = v; e.es = es; e.tag = tag;
      expq.push_back(e);
   endtask

   task automatic iss(input int w, input logic [1:0] dt, input int dst, input string tag);
      step(1, w, '0, '0, '0, dst, dt, 0, 0, 0, K0, 0, 0, tag);
   endtask

   task automatic probe(input int w, input logic [NR-1:0] im, fm, vm,
                        input bit es, input string tag);
      step(1, w, im, fm, vm, 0, K0, 0, 0, 0, K0, 0, es, tag);
   endtask

   task automatic wb(input int w, input int d, input logic [1:0] t, input string tag);
      step(0, 0, '0, '0, '0, 0, K0, 1, w, d, t, 0, 0, tag);
   endtask

   // monitor: samples mid-cycle, away from both edges
   always @(negedge clk) begin
      #2;
      if (expq.size() > 0) begin
         exp_t e;
         bit eg;
         e = expq.pop_front();
         eg = e.v && !e.es;
         checks++;
         if (iss_stall !== e.es || iss_go !== eg) begin
            errors++;
            $display("FAIL %s: stall=%b go=%b expected stall=%b go=%b",
                     e.tag, iss_stall, iss_go, e.es, eg);
         end
      end
   end

   initial begin
      #500000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      probe(0, '1, '1, '1, 0, "R1 reset empty");

      iss(0, KI, 5, "R5 int issue");
      probe(0, b(5), '0, '0, 1, "R5 int marked");
      probe(1, b(5), '0, '0, 0, "R3 other warp int");
      probe(0, '0, b(5), '0, 0, "R3 other class");
      probe(0, b(4) | b(6), '0, '0, 0, "R10 neighbour bits");

      iss(0, KI, 0, "R6 issue x0");
      probe(0, b(0), '0, '0, 0, "R6 x0 never busy");

      iss(1, KF, 7, "R5 float issue");
      probe(1, '0, b(7), '0, 1, "R5 float marked");
      probe(0, '0, b(7), '0, 0, "R3 float per warp");
      probe(1, b(7), '0, '0, 0, "R3 float vs int");

      iss(2, KV, 3, "R5 vector issue");
      probe(0, '0, '0, b(3), 1, "R4 shared seen by warp0");
      probe(3, '0, '0, b(3), 1, "R4 shared seen by warp3");

      iss(3, K0, 9, "R5 no-dest issue");
      probe(3, b(9), b(9), b(9), 0, "R5 class 0 marks nothing");

      step(1, 0, b(5), '0, '0, 9, KI, 0, 0, 0, K0, 0, 1, "R7 stalled issue");
      probe(0, b(9), '0, '0, 0, "R7 stalled marks nothing");

      step(1, 1, '0, b(7), '0, 0, K0, 1, 1, 7, KF, 0, 1, "R9 free not seen same cycle");
      probe(1, '0, b(7), '0, 0, "R8 float freed");

      wb(0, 5, KI, "R2 idle during wb");
      probe(0, b(5), '0, '0, 0, "R8 int freed");

      iss(2, KI, 11, "R5 int issue w2");
      step(1, 2, '0, '0, '0, 11, KI, 1, 2, 11, KI, 0, 0, "R9 issue+wb same bit");
      probe(2, b(11), '0, '0, 1, "R9 mark wins over free");
      wb(2, 11, KI, "R2 idle");
      probe(2, b(11), '0, '0, 0, "R8 freed after reissue");

      wb(0, 3, KV, "R2 idle");
      probe(2, '0, '0, b(3), 0, "R4 shared free from other warp");

      iss(1, KI, 20, "R5 int issue w1");
      wb(1, 20, K0, "R2 idle");
      probe(1, b(20), '0, '0, 1, "R8 class 0 wb ignored");
      wb(0, 20, KI, "R2 idle");
      probe(1, b(20), '0, '0, 1, "R3 wb other warp ignored");

      iss(3, KI, 4, "R5");
      iss(1, KF, 2, "R5");
      iss(0, KV, 8, "R5");
      probe(3, b(4), '0, '0, 1, "R5 int w3 marked");
      step(1, 0, '0, '0, '0, 6, KI, 0, 0, 0, K0, 1, 0, "R1 issue during clear");
      probe(3, b(4), '0, '0, 0, "R1 int cleared");
      probe(1, '0, b(2), '0, 0, "R1 float cleared");
      probe(0, '0, '0, b(8), 0, "R1 vector cleared");
      probe(0, b(6), '0, '0, 0, "R1 clear beats mark");
      probe(1, b(20), '0, '0, 0, "R1 older bit cleared");

      step(0, 0, '0, '0, '0, 0, K0, 0, 0, 0, K0, 0, 0, "R2 idle");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule